// File: doc/BRIEF.md
# Ternary Line Code Decoder

This block turns a three-level line symbol stream back into binary data. Each symbol arrives as three strobes: negative pulse, zero level and positive pulse. A sample strobe marks the cycles that carry a symbol. A zero level gives a 0. A pulse gives a 1 as long as it alternates in polarity with the pulse before it.

The matching encoder replaces every run of four zeros with a substitution pattern. The pattern ends in a violation pulse, which has the same polarity as the previous pulse. Some patterns also start with a balancing pulse. The decoder remembers the polarity of the last pulse. When a pulse repeats that polarity, the decoder marks the pulse as 0. It also clears the symbol that arrived three samples earlier, which restores the four zeros.

Decoded bits wait in a short delay line until any such rewrite can no longer reach them. A sample that does not assert exactly one strobe is flagged on an error output and decoded as 0.

Top module: `tlc_decoder`

## Requirements
- R1: With polarity alternating, a zero-level symbol decodes to 0 and a negative or positive pulse decodes to 1.
- R2: With the default latency LAT=4, the symbol taken on the k-th enabled cycle after reset is presented on `bit_out`, with `bit_stb` high, right after the rising edge of enabled cycle k+3. No strobe is produced for the first three enabled cycles after reset.
- R3: A pulse whose polarity equals the last pulse's polarity decodes to 0. It also forces to 0 the symbol that was taken three enabled cycles before it.
- R4: The stored last-pulse polarity is updated by every legal pulse, violations included. Reset sets it to negative, so the first positive pulse after reset is a normal 1 and the first negative pulse is a violation.
- R5: An enabled sample whose three strobes are not exactly one-hot decodes to 0. It sets `code_err` high for the one cycle after that edge and leaves the stored polarity unchanged.
- R6: On cycles with `sym_en` low, the line inputs are ignored. Nothing shifts, `bit_stb` and `code_err` are low and `bit_out` holds its value.
- R7: Synchronous active-low reset clears the delay line, the valid pipeline, `bit_out`, `bit_stb` and `code_err`.
- R8: A stream produced by the matching encoder decodes to its original bits. The encoder uses both substitution forms: three zeros then a violation, or a balancing pulse, two zeros, then a violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_en | input | 1 | Marks a cycle that carries a line symbol |
| sym_n | input | 1 | Negative-pulse strobe |
| sym_z | input | 1 | Zero-level strobe |
| sym_p | input | 1 | Positive-pulse strobe |
| bit_out | output | 1 | Decoded bit, held between strobes |
| bit_stb | output | 1 | High for one cycle when `bit_out` carries a new bit |
| code_err | output | 1 | High for one cycle after a non-one-hot enabled sample |

## Verification
The hardest case is a balancing pulse that is cancelled after it has already travelled three stages down the delay line. This case interacts with idle gaps between samples and with illegal samples that must not disturb the polarity memory.

A bench encoder turns random, zero-heavy bit sequences into legal streams with both substitution forms. This makes balancing pulses and violations occur often. The bench then interleaves disabled cycles carrying junk on the line, and it mixes raw random symbols with illegal combinations. A behavioural reference model checks every clock.

// File: rtl/tlc_dec_pkg.sv
`timescale 1ns/1ps
// Package: shared types and constants for the ternary line code decoder.
// Assumes: a violation always refers back exactly three symbol slots.
package tlc_dec_pkg;

    typedef enum logic {
        POL_NEG = 1'b0,
        POL_POS = 1'b1
    } pol_e;

    // Distance, in accepted symbols, from a violation back to its balancing pulse.
    localparam int CANCEL_BACK = 3;

endpackage

// File: rtl/tlc_sym_classify.sv
`timescale 1ns/1ps
// Module: tlc_sym_classify
// Classifies one line sample into legal / pulse / polarity.
// Assumes: purely combinational; sample validity (enable) is handled by the caller.
module tlc_sym_classify
    import tlc_dec_pkg::*;
(
    input  logic in_n,
    input  logic in_z,
    input  logic in_p,
    output logic legal,
    output logic pulse,
    output pol_e pol
);

    // Decide legality and pulse polarity of the current sample.
    always_comb begin
        legal = (in_n & ~in_z & ~in_p) | (~in_n & in_z & ~in_p) | (~in_n & ~in_z & in_p);
        pulse = legal & (in_n | in_p);
        pol   = in_p ? POL_POS : POL_NEG;
    end

endmodule

// File: rtl/tlc_pol_tracker.sv
`timescale 1ns/1ps
// Module: tlc_pol_tracker
// Remembers the polarity of the last legal pulse and flags a repeat of it.
// Assumes: pulse is already qualified as legal; reset polarity is negative,
// matching the encoder, so the first positive pulse is not a violation.
module tlc_pol_tracker
    import tlc_dec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pulse,
    input  pol_e pol,
    output logic viol
);

    pol_e last_q;

    // Compare the incoming pulse against the remembered polarity.
    always_comb begin
        viol = pulse & (pol == last_q);
    end

    // Record the polarity of every accepted pulse (a violation repeats it anyway).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= POL_NEG;
        end else if (en && pulse) begin
            last_q <= pol;
        end
    end

endmodule

// File: rtl/tlc_delay_line.sv
`timescale 1ns/1ps
// Module: tlc_delay_line
// Shift register of decoded bits with a valid pipeline. A cancel request
// clears the bit that was accepted CANCEL_BACK enables earlier as it moves on.
// Assumes: LAT > CANCEL_BACK so the cancelled bit has not yet been emitted.
module tlc_delay_line
    import tlc_dec_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    input  logic cancel,
    output logic dout,
    output logic stb
);

    logic data_q [LAT];
    logic vld_q  [LAT];
    logic stb_q;

    if (LAT < CANCEL_BACK + 1) begin : g_bad_lat
        $error("tlc_delay_line: LAT must exceed CANCEL_BACK");
    end

    // Load the newest decoded bit into the head slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q[0] <= 1'b0;
            vld_q[0]  <= 1'b0;
        end else if (en) begin
            data_q[0] <= din;
            vld_q[0]  <= 1'b1;
        end
    end

    for (genvar g = 1; g < LAT; g++) begin : g_stage
        if (g == CANCEL_BACK) begin : g_cancel
            // Advance one slot, clearing the bit a violation refers back to.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    data_q[g] <= 1'b0;
                    vld_q[g]  <= 1'b0;
                end else if (en) begin
                    data_q[g] <= data_q[g-1] & ~cancel;
                    vld_q[g]  <= vld_q[g-1];
                end
            end
        end else begin : g_plain
            // Advance one slot unchanged.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    data_q[g] <= 1'b0;
                    vld_q[g]  <= 1'b0;
                end else if (en) begin
                    data_q[g] <= data_q[g-1];
                    vld_q[g]  <= vld_q[g-1];
                end
            end
        end
    end

    // Strobe the output when a valid bit reaches the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= 1'b0;
        end else begin
            stb_q <= en & vld_q[LAT-2];
        end
    end

    assign dout = data_q[LAT-1];
    assign stb  = stb_q;

endmodule

// File: rtl/tlc_decoder.sv
`timescale 1ns/1ps
// Module: tlc_decoder (top)
// Rebuilds the binary stream from one-hot three-level line strobes, undoing
// four-zero substitutions by detecting polarity violations.
// Assumes: the stream comes from the matching encoder; non-one-hot samples
// are flagged and decoded as 0. Latency is LAT enabled cycles.
module tlc_decoder
    import tlc_dec_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sym_en,
    input  logic sym_n,
    input  logic sym_z,
    input  logic sym_p,
    output logic bit_out,
    output logic bit_stb,
    output logic code_err
);

    logic sym_legal;
    logic sym_pulse;
    pol_e sym_pol;
    logic pol_viol;
    logic dec_bit;
    logic err_q;

    tlc_sym_classify u_classify (
        .in_n  (sym_n),
        .in_z  (sym_z),
        .in_p  (sym_p),
        .legal (sym_legal),
        .pulse (sym_pulse),
        .pol   (sym_pol)
    );

    tlc_pol_tracker u_tracker (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sym_en),
        .pulse (sym_pulse),
        .pol   (sym_pol),
        .viol  (pol_viol)
    );

    // A pulse counts as a 1 only when it alternates.
    always_comb begin
        dec_bit = sym_pulse & ~pol_viol;
    end

    tlc_delay_line #(.LAT(LAT)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (sym_en),
        .din    (dec_bit),
        .cancel (pol_viol),
        .dout   (bit_out),
        .stb    (bit_stb)
    );

    // Flag a non-one-hot enabled sample for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= sym_en & ~sym_legal;
        end
    end

    assign code_err = err_q;

endmodule

// File: rtl/tlc_decoder_chk.sv
`timescale 1ns/1ps
// Module: tlc_decoder_chk
// Assertion checker bound to tlc_decoder.
// Assumes: synchronous active-low reset; all properties are disabled in reset.
module tlc_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic sym_en,
    input logic legal,
    input logic viol,
    input logic bit_out,
    input logic bit_stb,
    input logic code_err
);

    a_r6_stb_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> $past(sym_en));

    a_r5_err_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |-> $past(sym_en));

    a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sym_en) |-> $stable(bit_out));

    a_r3_viol_clears_back: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_en && viol) |=> !bit_out);

    a_r5_illegal_no_viol: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |-> !viol);

endmodule

bind tlc_decoder tlc_decoder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_en   (sym_en),
    .legal    (sym_legal),
    .viol     (pol_viol),
    .bit_out  (bit_out),
    .bit_stb  (bit_stb),
    .code_err (code_err)
);

// File: tb/tlc_decoder_bench.sv
`timescale 1ns/1ps
// Bench for tlc_decoder: behavioural reference model compared every clock.
module tlc_decoder_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_en = 1'b0, sym_n = 1'b0, sym_z = 1'b0, sym_p = 1'b0;
    logic bit_out, bit_stb, code_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    int   m_k;
    bit   m_last;           // 0 = negative, 1 = positive
    bit   m_bits[$];
    bit   e_out, e_stb, e_err;
    bit   collect = 1'b0;
    bit   rx[$];

    always #5 clk = ~clk;

    tlc_decoder u_tlc_decoder (
        .clk(clk), .rst_n(rst_n), .sym_en(sym_en),
        .sym_n(sym_n), .sym_z(sym_z), .sym_p(sym_p),
        .bit_out(bit_out), .bit_stb(bit_stb), .code_err(code_err)
    );

    task automatic check(string tag, string what, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_k = 0; m_last = 1'b0; m_bits.delete();
        e_out = 1'b0; e_stb = 1'b0; e_err = 1'b0;
    endtask

    // sym code: 0 = z, 1 = n, 2 = p, 3 = none, 4 = n+p, 5 = all
    task automatic cyc(bit e, int sym, string tag);
        bit n, z, p, legal, pulse, pol, viol, b;
        n = (sym == 1 || sym == 4 || sym == 5);
        z = (sym == 0 || sym == 5);
        p = (sym == 2 || sym == 4 || sym == 5);
        sym_en = e; sym_n = n; sym_z = z; sym_p = p;
        if (e) begin
            legal = (int'(n) + int'(z) + int'(p)) == 1;
            pulse = legal && (n || p);
            pol   = p;
            viol  = pulse && (pol == m_last);
            if (pulse) m_last = pol;
            b = pulse && !viol;
            m_bits.push_back(b);
            if (viol && m_k >= 3) m_bits[m_k-3] = 1'b0;
            if (m_k >= 3) begin e_out = m_bits[m_k-3]; e_stb = 1'b1; end
            else begin e_out = 1'b0; e_stb = 1'b0; end
            e_err = !legal;
            m_k++;
        end else begin
            e_stb = 1'b0; e_err = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "bit_out", bit_out, e_out);
        check(tag, "bit_stb", bit_stb, e_stb);
        check(tag, "code_err", code_err, e_err);
        if (collect && bit_stb) rx.push_back(bit_out);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sym_en = 1'b1; sym_p = 1'b1; sym_n = 1'b0; sym_z = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sym_en = 1'b0;
        model_reset();
        // R7: outputs clear after reset
        check("R7", "bit_out after reset", bit_out, 1'b0);
        check("R7", "bit_stb after reset", bit_stb, 1'b0);
        check("R7", "code_err after reset", code_err, 1'b0);
    endtask

    // build encoder symbols for a bit list (both substitution forms)
    task automatic encode(input bit src[$], output int syms[$]);
        bit last = 1'b0;
        int ones = 0;
        int i = 0;
        syms.delete();
        while (i < src.size()) begin
            if (i + 3 < src.size() && !src[i] && !src[i+1] && !src[i+2] && !src[i+3]) begin
                if (ones % 2 == 1) begin
                    syms.push_back(0); syms.push_back(0); syms.push_back(0);
                end else begin
                    last = !last;
                    syms.push_back(last ? 2 : 1); syms.push_back(0); syms.push_back(0);
                end
                syms.push_back(last ? 2 : 1);
                ones = 0;
                i += 4;
            end else begin
                if (src[i]) begin
                    last = !last;
                    syms.push_back(last ? 2 : 1);
                    ones++;
                end else begin
                    syms.push_back(0);
                end
                i++;
            end
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int syms[$];
        bit src[$];
        do_reset();

        // R1 / R2: alternating pulses and zeros, first strobe on 4th enable
        cyc(1, 2, "R2"); cyc(1, 0, "R2"); cyc(1, 1, "R2");
        cyc(1, 0, "R1"); cyc(1, 2, "R1"); cyc(1, 1, "R1");
        cyc(1, 0, "R1"); cyc(1, 0, "R1"); cyc(1, 0, "R1");

        // R6: idle cycles with junk on the line
        cyc(0, 5, "R6"); cyc(0, 1, "R6"); cyc(0, 3, "R6");
        cyc(1, 2, "R6"); cyc(0, 2, "R6"); cyc(1, 0, "R6");
        cyc(0, 4, "R6"); cyc(1, 0, "R6"); cyc(1, 0, "R6"); cyc(0, 0, "R6");

        // R4: first negative pulse after reset is a violation
        do_reset();
        cyc(1, 1, "R4"); cyc(1, 2, "R4"); cyc(1, 1, "R4");
        cyc(1, 0, "R4"); cyc(1, 0, "R4"); cyc(1, 0, "R4");

        // R3: balancing pulse cancelled, with gaps inside the window
        do_reset();
        cyc(1, 2, "R3"); cyc(1, 0, "R3"); cyc(0, 0, "R3"); cyc(1, 0, "R3");
        cyc(0, 1, "R3"); cyc(1, 2, "R3");
        cyc(1, 1, "R3"); cyc(1, 0, "R3"); cyc(1, 0, "R3"); cyc(1, 1, "R3");
        cyc(1, 0, "R3"); cyc(1, 0, "R3"); cyc(1, 0, "R3");

        // R5: illegal samples do not change polarity
        do_reset();
        cyc(1, 2, "R5"); cyc(1, 3, "R5"); cyc(1, 4, "R5"); cyc(1, 5, "R5");
        cyc(1, 1, "R5"); cyc(1, 0, "R5"); cyc(1, 0, "R5"); cyc(1, 0, "R5");

        // R8: encoded random zero-heavy streams round-trip
        for (int run = 0; run < 6; run++) begin
            do_reset();
            src.delete();
            for (int j = 0; j < 300; j++) src.push_back(($urandom % 3) == 0);
            encode(src, syms);
            rx.delete();
            collect = 1'b1;
            foreach (syms[j]) begin
                if (($urandom % 4) == 0) cyc(0, int'($urandom % 6), "R8");
                cyc(1, syms[j], "R8");
            end
            for (int j = 0; j < 3; j++) cyc(1, 0, "R8");
            collect = 1'b0;
            check("R8", "round-trip length", rx.size() == syms.size(), 1'b1);
            for (int j = 0; j < src.size() && j < rx.size(); j++)
                check("R8", "round-trip bit", rx[j], src[j]);
        end

        // R3 / R5: raw random symbols including illegal ones
        do_reset();
        for (int j = 0; j < 2000; j++)
            cyc(($urandom % 5) != 0, (($urandom % 8) < 6) ? int'($urandom % 3) : int'(3 + $urandom % 3), "R3");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule